// File: doc/BRIEF.md
# TFT Panel Command Packet Sequencer

This block sits between a pixel source and an intelligent TFT panel controller that accepts commands over a write-only 8-bit parallel bus. It takes a rectangular image as a stream of 16-bit RGB pixels and cuts every image line into fixed-size pixel packets. Each packet opens with an opcode byte and a length byte, carries the payload bytes of its pixels, and is then closed by a terminator write. The only address line the panel decodes is a single select output, which chooses between the packet register and the end-of-packet register.

Every byte goes out as one bus write whose setup, strobe-low and hold phases each last a set number of clock cycles, given as parameters. The frame starts when a pixel is offered while the block is idle. The origin inputs are captured at that moment. From then on the block reports the linear frame-memory byte address of the packet in flight, for a memory that holds two bytes per pixel. A one-cycle done pulse marks the end of the frame.

Top module: `tftpkt_seq`

## Requirements
- R1: Every packet begins with the opcode byte 0x84, followed by a length byte equal to 2*PKT_PIX (40 with the default of 20 pixels). Both are written with lcd_sel = 0.
- R2: After the length byte come PKT_PIX pixels in input order. Each pixel is written as its low byte (pix_data[7:0]) first and then its high byte (pix_data[15:8]), all with lcd_sel = 0.
- R3: A packet is closed by writing the value 0x01 with lcd_sel = 1. No other write uses lcd_sel = 1.
- R4: Each line of IMG_W pixels yields IMG_W/PKT_PIX packets, and a frame consists of IMG_H lines.
- R5: Every write keeps lcd_cs_n low for SETUP_CYC+STROBE_CYC+HOLD_CYC cycles. Within that window lcd_we_n is high for SETUP_CYC cycles, then low for STROBE_CYC cycles, then high for HOLD_CYC cycles. lcd_d and lcd_sel stay stable throughout, lcd_we_n is never low while lcd_cs_n is high, and lcd_cs_n goes high for at least one cycle between two writes.
- R6: pix_ready is low while the bus is in a write (lcd_cs_n low), which covers every opcode, length and terminator write. It is also low while no frame is active.
- R7: A frame starts only when pix_valid is high while the block is idle. Without it, no bus write occurs.
- R8: While a packet's writes are in progress, pkt_addr equals (org_x + k*PKT_PIX)*2 + (org_y + l)*MEM_W*2. Here k is the packet index within the line, l is the line index, and org_x and org_y are the values captured at frame start.
- R9: frame_done is high for exactly one cycle: the first cycle with lcd_cs_n high after the last terminator write of the last line. It is low at all other times.
- R10: During and right after a synchronous reset, lcd_cs_n = 1, lcd_we_n = 1, pix_ready = 0 and frame_done = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | A pixel is offered on pix_data |
| pix_ready | output | 1 | The block takes the offered pixel in this cycle |
| pix_data | input | 16 | RGB pixel, high byte in [15:8] |
| org_x | input | X_W | Image origin column, captured at frame start |
| org_y | input | Y_W | Image origin row, captured at frame start |
| pkt_addr | output | ADDR_W | Frame-memory byte address of the first pixel of the current packet |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_we_n | output | 1 | Panel write strobe, active low |
| lcd_sel | output | 1 | Register select: 0 for packet bytes, 1 for the terminator |
| lcd_d | output | 8 | Bus data byte |
| frame_done | output | 1 | One-cycle pulse at the end of the frame |

## Verification
The bench builds the block with an image two packets wide and three lines tall. Setup is 2, strobe is 3 and hold is at its minimum of 1. This lets the run reach packet changes within a line as well as line changes within a frame, and the address step of 640 bytes per line. With distinct phase lengths, a swapped or off-by-one phase counter shows up as a wrong pulse width. Two frames run back to back, one with gaps in pix_valid and one with a continuous stream from a different origin, so that frame restart and origin capture are both exercised.

// File: rtl/tftpkt_pkg.sv
package tftpkt_pkg;

    localparam logic [7:0] PKT_OPCODE = 8'h84;
    localparam logic [7:0] PKT_CLOSE  = 8'h01;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_OPC,
        SQ_LEN,
        SQ_PLO,
        SQ_PHI,
        SQ_TERM
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } wr_phase_e;

    typedef struct packed {
        logic [7:0] data;
        logic       sel;
    } bus_word_t;

    // linear byte address of pixel (x, y) in a memory mem_w pixels wide
    function automatic int unsigned byte_addr(input int unsigned x,
                                              input int unsigned y,
                                              input int unsigned mem_w);
        return x * 2 + y * mem_w * 2;
    endfunction

    // clamp a phase length to at least one cycle
    function automatic logic [3:0] min_one(input logic [3:0] v);
        return (v == 4'd0) ? 4'd1 : v;
    endfunction

endpackage

// File: rtl/tftpkt_strobe.sv
module tftpkt_strobe
    import tftpkt_pkg::*;
#(
    parameter logic [3:0] SETUP_CYC  = 4'd1,
    parameter logic [3:0] STROBE_CYC = 4'd1,
    parameter logic [3:0] HOLD_CYC   = 4'd1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  bus_word_t word_in,
    output logic      busy,
    output logic      last,
    output logic      cs_n,
    output logic      we_n,
    output bus_word_t word_out
);

    localparam logic [3:0] SET_LAST = min_one(SETUP_CYC) - 4'd1;
    localparam logic [3:0] STB_LAST = min_one(STROBE_CYC) - 4'd1;
    localparam logic [3:0] HLD_LAST = min_one(HOLD_CYC) - 4'd1;

    wr_phase_e  ph;
    logic [3:0] cnt;
    bus_word_t  held;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            held <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph   <= PH_SETUP;
                        cnt  <= SET_LAST;
                        held <= word_in;
                    end
                end
                PH_SETUP: begin
                    if (cnt == 4'd0) begin
                        ph  <= PH_STROBE;
                        cnt <= STB_LAST;
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                PH_STROBE: begin
                    if (cnt == 4'd0) begin
                        ph  <= PH_HOLD;
                        cnt <= HLD_LAST;
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == 4'd0) begin
                        ph <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (ph != PH_IDLE);
    assign last     = (ph == PH_HOLD) && (cnt == 4'd0);
    assign cs_n     = (ph == PH_IDLE);
    assign we_n     = (ph != PH_STROBE);
    assign word_out = held;

endmodule

// File: rtl/tftpkt_cursor.sv
module tftpkt_cursor
    import tftpkt_pkg::*;
#(
    parameter int unsigned ADDR_W  = 18,
    parameter int unsigned X_W     = 9,
    parameter int unsigned Y_W     = 8,
    parameter int unsigned MEM_W   = 320,
    parameter int unsigned PKT_PIX = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [X_W-1:0]    org_x,
    input  logic [Y_W-1:0]    org_y,
    input  logic              next_pkt,
    input  logic              next_line,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] PKT_BYTES  = ADDR_W'(2 * PKT_PIX);
    localparam logic [ADDR_W-1:0] LINE_BYTES = ADDR_W'(2 * MEM_W);

    logic [ADDR_W-1:0] line_base;
    logic [ADDR_W-1:0] pkt_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_base <= '0;
            pkt_base  <= '0;
        end else if (load) begin
            line_base <= ADDR_W'(byte_addr(32'(org_x), 32'(org_y), MEM_W));
            pkt_base  <= ADDR_W'(byte_addr(32'(org_x), 32'(org_y), MEM_W));
        end else if (next_line) begin
            line_base <= line_base + LINE_BYTES;
            pkt_base  <= line_base + LINE_BYTES;
        end else if (next_pkt) begin
            pkt_base  <= pkt_base + PKT_BYTES;
        end
    end

    assign addr = pkt_base;

endmodule

// File: rtl/tftpkt_seq.sv
module tftpkt_seq
    import tftpkt_pkg::*;
#(
    parameter int unsigned IMG_W      = 320,
    parameter int unsigned IMG_H      = 240,
    parameter int unsigned PKT_PIX    = 20,
    parameter int unsigned MEM_W      = 320,
    parameter int unsigned X_W        = 9,
    parameter int unsigned Y_W        = 8,
    parameter int unsigned ADDR_W     = 18,
    parameter logic [3:0]  SETUP_CYC  = 4'd1,
    parameter logic [3:0]  STROBE_CYC = 4'd1,
    parameter logic [3:0]  HOLD_CYC   = 4'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    output logic              pix_ready,
    input  logic [15:0]       pix_data,
    input  logic [X_W-1:0]    org_x,
    input  logic [Y_W-1:0]    org_y,
    output logic [ADDR_W-1:0] pkt_addr,
    output logic              lcd_cs_n,
    output logic              lcd_we_n,
    output logic              lcd_sel,
    output logic [7:0]        lcd_d,
    output logic              frame_done
);

    localparam int unsigned PKTS_PER_LINE = IMG_W / PKT_PIX;
    localparam int unsigned PIX_CW  = (PKT_PIX > 1)       ? $clog2(PKT_PIX)       : 1;
    localparam int unsigned PKT_CW  = (PKTS_PER_LINE > 1) ? $clog2(PKTS_PER_LINE) : 1;
    localparam int unsigned LINE_CW = (IMG_H > 1)         ? $clog2(IMG_H)         : 1;
    localparam logic [PIX_CW-1:0]  PIX_LAST  = PIX_CW'(PKT_PIX - 1);
    localparam logic [PKT_CW-1:0]  PKT_LAST  = PKT_CW'(PKTS_PER_LINE - 1);
    localparam logic [LINE_CW-1:0] LINE_LAST = LINE_CW'(IMG_H - 1);
    localparam logic [7:0]         LEN_BYTE  = 8'(2 * PKT_PIX);

    seq_state_e         st;
    logic [PIX_CW-1:0]  pix_i;
    logic [PKT_CW-1:0]  pkt_i;
    logic [LINE_CW-1:0] line_i;
    logic [7:0]         hi_byte;
    logic               done_q;

    logic      wr_start;
    logic      wr_busy;
    logic      wr_last;
    bus_word_t wr_word;
    bus_word_t bus_word;

    logic frame_load;
    logic last_pkt;
    logic last_line;
    logic step_pkt;
    logic step_line;

    // byte selection and write launch for the current state
    always_comb begin
        wr_word   = '{data: 8'h00, sel: 1'b0};
        wr_start  = 1'b0;
        pix_ready = 1'b0;
        unique case (st)
            SQ_OPC: begin
                wr_word.data = PKT_OPCODE;
                wr_start     = !wr_busy;
            end
            SQ_LEN: begin
                wr_word.data = LEN_BYTE;
                wr_start     = !wr_busy;
            end
            SQ_PLO: begin
                wr_word.data = pix_data[7:0];
                pix_ready    = !wr_busy;
                wr_start     = !wr_busy && pix_valid;
            end
            SQ_PHI: begin
                wr_word.data = hi_byte;
                wr_start     = !wr_busy;
            end
            SQ_TERM: begin
                wr_word.data = PKT_CLOSE;
                wr_word.sel  = 1'b1;
                wr_start     = !wr_busy;
            end
            default: ;
        endcase
    end

    assign frame_load = (st == SQ_IDLE) && pix_valid;
    assign last_pkt   = (pkt_i == PKT_LAST);
    assign last_line  = (line_i == LINE_LAST);
    assign step_pkt   = (st == SQ_TERM) && wr_last && !last_pkt;
    assign step_line  = (st == SQ_TERM) && wr_last && last_pkt && !last_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            pix_i   <= '0;
            pkt_i   <= '0;
            line_i  <= '0;
            hi_byte <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                SQ_IDLE: begin
                    pix_i  <= '0;
                    pkt_i  <= '0;
                    line_i <= '0;
                    if (pix_valid) st <= SQ_OPC;
                end
                SQ_OPC: if (wr_last) st <= SQ_LEN;
                SQ_LEN: if (wr_last) st <= SQ_PLO;
                SQ_PLO: begin
                    if (wr_start) hi_byte <= pix_data[15:8];
                    if (wr_last)  st      <= SQ_PHI;
                end
                SQ_PHI: begin
                    if (wr_last) begin
                        if (pix_i == PIX_LAST) begin
                            pix_i <= '0;
                            st    <= SQ_TERM;
                        end else begin
                            pix_i <= pix_i + 1'b1;
                            st    <= SQ_PLO;
                        end
                    end
                end
                SQ_TERM: begin
                    if (wr_last) begin
                        if (!last_pkt) begin
                            pkt_i <= pkt_i + 1'b1;
                            st    <= SQ_OPC;
                        end else begin
                            pkt_i <= '0;
                            if (last_line) begin
                                line_i <= '0;
                                done_q <= 1'b1;
                                st     <= SQ_IDLE;
                            end else begin
                                line_i <= line_i + 1'b1;
                                st     <= SQ_OPC;
                            end
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    tftpkt_strobe #(
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) i_strobe (
        .clk      (clk),
        .rst      (rst),
        .start    (wr_start),
        .word_in  (wr_word),
        .busy     (wr_busy),
        .last     (wr_last),
        .cs_n     (lcd_cs_n),
        .we_n     (lcd_we_n),
        .word_out (bus_word)
    );

    tftpkt_cursor #(
        .ADDR_W  (ADDR_W),
        .X_W     (X_W),
        .Y_W     (Y_W),
        .MEM_W   (MEM_W),
        .PKT_PIX (PKT_PIX)
    ) i_cursor (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_load),
        .org_x     (org_x),
        .org_y     (org_y),
        .next_pkt  (step_pkt),
        .next_line (step_line),
        .addr      (pkt_addr)
    );

    assign lcd_d      = bus_word.data;
    assign lcd_sel    = bus_word.sel;
    assign frame_done = done_q;

endmodule

// File: rtl/tftpkt_seq_chk.sv
module tftpkt_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       pix_ready,
    input logic       lcd_cs_n,
    input logic       lcd_we_n,
    input logic       lcd_sel,
    input logic [7:0] lcd_d,
    input logic       frame_done
);

    AST_STROBE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (rst)
        !lcd_we_n |-> !lcd_cs_n);  // R5

    AST_BUS_HELD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!lcd_cs_n && $past(!lcd_cs_n)) |-> ($stable(lcd_d) && $stable(lcd_sel)));  // R5

    AST_HOLD_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_cs_n) |-> $past(lcd_we_n));  // R5

    AST_NO_PIXEL_DURING_WRITE: assert property (@(posedge clk) disable iff (rst)
        !lcd_cs_n |-> !pix_ready);  // R6

    AST_CLOSE_VALUE: assert property (@(posedge clk) disable iff (rst)
        (!lcd_cs_n && lcd_sel) |-> (lcd_d == 8'h01));  // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);  // R9

    AST_DONE_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (lcd_cs_n && !pix_ready));  // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (lcd_cs_n && lcd_we_n && !pix_ready && !frame_done));  // R10

endmodule

bind tftpkt_seq tftpkt_seq_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_ready  (pix_ready),
    .lcd_cs_n   (lcd_cs_n),
    .lcd_we_n   (lcd_we_n),
    .lcd_sel    (lcd_sel),
    .lcd_d      (lcd_d),
    .frame_done (frame_done)
);

// File: tb/test_tftpkt_seq.sv
module test_tftpkt_seq;

    localparam int IMG_W   = 40;
    localparam int IMG_H   = 3;
    localparam int PKT_PIX = 20;
    localparam int MEM_W   = 320;
    localparam int X_W     = 9;
    localparam int Y_W     = 8;
    localparam int ADDR_W  = 18;
    localparam int T_SET   = 2;
    localparam int T_STB   = 3;
    localparam int T_HLD   = 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pix_valid = 1'b0;
    logic              pix_ready;
    logic [15:0]       pix_data = '0;
    logic [X_W-1:0]    org_x = '0;
    logic [Y_W-1:0]    org_y = '0;
    logic [ADDR_W-1:0] pkt_addr;
    logic              lcd_cs_n;
    logic              lcd_we_n;
    logic              lcd_sel;
    logic [7:0]        lcd_d;
    logic              frame_done;

    always #4 clk = ~clk;

    tftpkt_seq #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .PKT_PIX(PKT_PIX), .MEM_W(MEM_W),
        .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W),
        .SETUP_CYC(4'(T_SET)), .STROBE_CYC(4'(T_STB)), .HOLD_CYC(4'(T_HLD))
    ) i_tftpkt_seq (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_data(pix_data), .org_x(org_x), .org_y(org_y), .pkt_addr(pkt_addr),
        .lcd_cs_n(lcd_cs_n), .lcd_we_n(lcd_we_n), .lcd_sel(lcd_sel),
        .lcd_d(lcd_d), .frame_done(frame_done)
    );

    int n_vec = 0;
    int n_err = 0;
    bit finished = 0;

    // expected write stream of the current frame
    int exp_d[$];
    int exp_sel[$];
    int exp_addr[$];
    int pix_arr[$];
    int wr_idx = 0;
    bit done_seen = 0;
    bit mon_en = 0;

    // bus monitor state
    bit in_wr = 0;
    int s_cnt, p_cnt, h_cnt, cap_d, cap_sel, cap_addr;

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic build_frame(input int ox, input int oy, input int seed);
        exp_d.delete(); exp_sel.delete(); exp_addr.delete(); pix_arr.delete();
        for (int i = 0; i < IMG_W * IMG_H; i++)
            pix_arr.push_back(((i * 16'h0123) ^ seed) & 16'hFFFF);
        for (int l = 0; l < IMG_H; l++) begin
            for (int k = 0; k < IMG_W / PKT_PIX; k++) begin
                int a;
                a = (ox + k * PKT_PIX) * 2 + (oy + l) * MEM_W * 2;
                exp_d.push_back(8'h84);        exp_sel.push_back(0); exp_addr.push_back(a);
                exp_d.push_back(2 * PKT_PIX);  exp_sel.push_back(0); exp_addr.push_back(a);
                for (int p = 0; p < PKT_PIX; p++) begin
                    int v;
                    v = pix_arr[l * IMG_W + k * PKT_PIX + p];
                    exp_d.push_back(v & 8'hFF);        exp_sel.push_back(0); exp_addr.push_back(a);
                    exp_d.push_back((v >> 8) & 8'hFF); exp_sel.push_back(0); exp_addr.push_back(a);
                end
                exp_d.push_back(8'h01); exp_sel.push_back(1); exp_addr.push_back(a);
            end
        end
    endtask

    // per-clock comparison of the bus against the expected stream
    always @(negedge clk) begin
        if (mon_en) begin
            bit ended;
            ended = 0;
            if (!lcd_we_n) check("R5 strobe only with select", lcd_cs_n, 0);
            if (!lcd_cs_n) check("R6 ready low during write", pix_ready, 0);
            if (!lcd_cs_n) begin
                if (!in_wr) begin
                    in_wr = 1; s_cnt = 0; p_cnt = 0; h_cnt = 0;
                    cap_d = lcd_d; cap_sel = lcd_sel; cap_addr = pkt_addr;
                end else begin
                    check("R5 data stable", {lcd_sel, lcd_d}, {cap_sel[0], cap_d[7:0]});
                end
                if (!lcd_we_n) begin
                    p_cnt++;
                    if (h_cnt != 0) check("R5 single strobe", h_cnt, 0);
                end else if (p_cnt == 0) s_cnt++;
                else h_cnt++;
            end else if (in_wr) begin
                in_wr = 0;
                ended = 1;
                check("R5 setup cycles", s_cnt, T_SET);
                check("R5 strobe cycles", p_cnt, T_STB);
                check("R5 hold cycles", h_cnt, T_HLD);
                if (wr_idx < exp_d.size()) begin
                    check("R1/R2/R3/R4 byte", cap_d, exp_d[wr_idx]);
                    check("R1/R2/R3 select", cap_sel, exp_sel[wr_idx]);
                    check("R8 packet address", cap_addr, exp_addr[wr_idx]);
                end else begin
                    check("R4 extra write", wr_idx, exp_d.size() - 1);
                end
                wr_idx++;
            end
            if (ended && wr_idx == exp_d.size()) begin
                check("R9 done after last close", frame_done, 1);
                check("R6 ready low when idle", pix_ready, 0);
                done_seen = 1;
            end else if (frame_done) begin
                check("R9 stray done", frame_done, 0);
            end
        end
    end

    task automatic run_frame(input int ox, input int oy, input int seed, input bit gappy);
        int idx;
        int cyc;
        build_frame(ox, oy, seed);
        wr_idx = 0; done_seen = 0; idx = 0; cyc = 0;
        @(negedge clk);
        org_x = X_W'(ox); org_y = Y_W'(oy);
        while (!done_seen && !finished) begin
            @(negedge clk);
            if (idx < pix_arr.size()) begin
                pix_valid = gappy ? ((cyc % 3) != 1) : 1'b1;
                pix_data  = 16'(pix_arr[idx]);
            end else begin
                pix_valid = 1'b0;
            end
            #1;
            if (pix_valid && pix_ready) idx++;
            cyc++;
        end
        pix_valid = 1'b0;
        check("R4 pixels consumed", idx, IMG_W * IMG_H);
        check("R4 write count", wr_idx, IMG_H * (IMG_W / PKT_PIX) * (2 * PKT_PIX + 3));
    endtask

    task automatic quiet_window(input string req, input int cycles);
        int busy_seen;
        busy_seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!lcd_cs_n || frame_done || pix_ready) busy_seen++;
        end
        check(req, busy_seen, 0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R10 cs_n in reset", lcd_cs_n, 1);
        check("R10 we_n in reset", lcd_we_n, 1);
        check("R10 ready in reset", pix_ready, 0);
        check("R10 done in reset", frame_done, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 cs_n after reset", lcd_cs_n, 1);
        mon_en = 1;
        quiet_window("R7 no write without valid", 20);
        run_frame(3, 5, 16'h5A3C, 1'b1);
        quiet_window("R7 idle after frame", 15);
        run_frame(100, 200, 16'hC3A5, 1'b0);
        quiet_window("R9 single done pulse", 10);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule